// File: doc/BRIEF.md
# Masked Pattern Trigger with Match Counter

This block decides when a capture controller should start storing samples. Each qualified sample cycle it compares a trigger word against a programmed pattern. A per-bit care mask limits the comparison to selected positions. After arming, it counts the qualified samples that match. When the count reaches a programmed target, it emits a single-cycle trigger pulse and disarms itself.

A select input can switch the block to an external level. In that mode the pattern and the counter play no part, and the first qualified sample that sees the external level high fires the trigger. The trigger word width is a parameter and may be 8, 16, 32 or 64 bits. The match target width is also a parameter.

Top module: `pattern_trigger`

## Requirements
- R1: A sample matches when every bit position with `care_i` = 1 equals the same bit of `pat_i`. Positions with `care_i` = 0 are don't-care.
- R2: With `care_i` all zero, every qualified sample matches, so the first qualified sample after arming fires the trigger.
- R3: A `need_i` of 0 behaves exactly like 1: the first counted match fires the trigger.
- R4: A `need_i` of K > 1 fires the trigger on the K-th counted match. The matches need not be consecutive, and non-matching samples in between do not clear the count.
- R5: A sample is qualified only when the block is armed, `smp_en_i` is high and `arm_i` is low in that cycle. The sample taken in the arming cycle is never counted.
- R6: With `ext_sel_i` = 1, a qualified sample with `ext_lvl_i` high fires the trigger whatever the word, pattern and mask hold. With `ext_lvl_i` low it does not fire.
- R7: With `ext_sel_i` = 0, `ext_lvl_i` has no effect on the trigger.
- R8: `fire_o` rises in the clock cycle after the edge that sampled the firing condition and stays high for exactly one cycle. No further pulse is produced until `arm_i` is asserted again.
- R9: Asserting `arm_i` clears the match count and arms the block, even if it is already armed. After reset the block is disarmed with `fire_o` low.
- R10: All WORD_W bits take part in the comparison, including the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| arm_i | input | 1 | Arm pulse; clears the count and arms the block |
| smp_en_i | input | 1 | Sample strobe; marks cycles that carry a valid trigger word |
| word_i | input | WORD_W | Trigger word |
| pat_i | input | WORD_W | Pattern to match |
| care_i | input | WORD_W | Per-bit mask: 1 = compare, 0 = don't care |
| need_i | input | CNT_W | Number of matches needed (0 treated as 1) |
| ext_sel_i | input | 1 | 1 selects the external level as the trigger source |
| ext_lvl_i | input | 1 | External trigger level |
| fire_o | output | 1 | One-cycle trigger pulse to the capture controller |

## Verification
The embedded properties check on every cycle that the trigger pulse lasts one cycle and leaves the block disarmed, that an arm clears the count, and that the count steps by one per counted match. They also check that an all-zero mask always matches, and that the external level decides the outcome only when it is selected. Only the bench scenarios can show that the K-th match fires and not an earlier or later one. They also show that samples without the strobe, or in the arming cycle, are skipped, that a re-arm restarts the count, and that the top bit of the word is compared.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } pt_state_e;
endpackage

// File: rtl/pt_match.sv
module pt_match #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] pat_i,
  input  logic [WORD_W-1:0] care_i,
  output logic              hit_o
);
  import pt_pkg::*;

  localparam int unsigned NLANE = WORD_W / LANE_W;

  logic [NLANE-1:0] lane_miss;

  // One mismatch flag per byte lane, then a single reduction across lanes.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] diff;
    always_comb begin
      diff         = (word_i[g*LANE_W +: LANE_W] ^ pat_i[g*LANE_W +: LANE_W])
                     & care_i[g*LANE_W +: LANE_W];
      lane_miss[g] = |diff;
    end
  end

  always_comb begin
    hit_o = ~|lane_miss;
  end
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] need_eff;
  logic [CNT_W:0]   cnt_plus;
  logic             cnt_en;

  always_comb begin
    need_eff = (need_i == '0) ? CNT_ONE : need_i;
    cnt_plus = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    last_o   = inc_i && (cnt_plus >= {1'b0, need_eff});
  end

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != CNT_MAX));
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_plus[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)) else $error("count not cleared by arm"); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + CNT_ONE))
    else $error("count did not advance on a counted match"); // R4
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic smp_en_i,
  input  logic ext_sel_i,
  input  logic ext_lvl_i,
  input  logic cnt_last_i,
  output logic sample_ok_o,
  output logic fire_o
);
  import pt_pkg::*;

  pt_state_e state_q, state_d;
  logic      fire_q, fire_d;
  logic      go;

  always_comb begin
    sample_ok_o = (state_q == ST_ARMED) && smp_en_i && !arm_i;
    go          = sample_ok_o && (ext_sel_i ? ext_lvl_i : cnt_last_i);
  end

  always_comb begin
    state_d = state_q;
    fire_d  = 1'b0;
    if (arm_i) begin
      state_d = ST_ARMED;
    end else if (go) begin
      state_d = ST_IDLE;
      fire_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fire_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire_d;
    end
  end

  assign fire_o = fire_q;

  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q) else $error("trigger longer than one cycle"); // R8

  AST_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !arm_i) |=> (state_q == ST_IDLE)) else $error("still armed after firing"); // R8

  AST_EXT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ok_o && ext_sel_i && ext_lvl_i) |=> fire_q)
    else $error("external level did not fire"); // R6

  AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ok_o && !ext_sel_i && !cnt_last_i) |=> !fire_q)
    else $error("fired without reaching the count"); // R7
endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              smp_en_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] pat_i,
  input  logic [WORD_W-1:0] care_i,
  input  logic [CNT_W-1:0]  need_i,
  input  logic              ext_sel_i,
  input  logic              ext_lvl_i,
  output logic              fire_o
);
  logic match_hit;
  logic sample_ok;
  logic cnt_inc;
  logic cnt_last;

  pt_match #(.WORD_W(WORD_W)) u_match (
    .word_i (word_i),
    .pat_i  (pat_i),
    .care_i (care_i),
    .hit_o  (match_hit)
  );

  always_comb begin
    cnt_inc = sample_ok && !ext_sel_i && match_hit;
  end

  pt_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (arm_i),
    .inc_i  (cnt_inc),
    .need_i (need_i),
    .last_o (cnt_last)
  );

  pt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .smp_en_i    (smp_en_i),
    .ext_sel_i   (ext_sel_i),
    .ext_lvl_i   (ext_lvl_i),
    .cnt_last_i  (cnt_last),
    .sample_ok_o (sample_ok),
    .fire_o      (fire_o)
  );

  AST_DONTCARE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (care_i == '0) |-> match_hit) else $error("empty mask did not match"); // R2

  AST_MATCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (((word_i ^ pat_i) & care_i) != '0) |-> !cnt_inc)
    else $error("mismatch was counted"); // R1
endmodule

// File: tb/tb_pattern_trigger.sv
`timescale 1ns/1ps
module tb_pattern_trigger;
  localparam int W = 16;
  localparam int C = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arm = 1'b0, smp = 1'b0, ext_sel = 1'b0, ext_lvl = 1'b0;
  logic [W-1:0] word = '0, pat = '0, care = '0;
  logic [C-1:0] need = '0;
  logic         fire;

  int checks = 0, fails = 0, fires = 0;
  bit done = 0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  pattern_trigger #(.WORD_W(W), .CNT_W(C)) dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .smp_en_i(smp), .word_i(word),
    .pat_i(pat), .care_i(care), .need_i(need), .ext_sel_i(ext_sel),
    .ext_lvl_i(ext_lvl), .fire_o(fire)
  );

  // Behavioural reference model
  bit m_armed = 0;
  int m_cnt = 0;
  bit m_fire = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_cnt = 0; m_fire = 0;
    end else begin
      m_fire = 0;
      if (arm) begin
        m_armed = 1; m_cnt = 0;
      end else if (m_armed && smp) begin
        if (ext_sel) begin
          if (ext_lvl) begin m_fire = 1; m_armed = 0; end
        end else if (((word ^ pat) & care) == 0) begin
          m_cnt++;
          if (m_cnt >= ((need == 0) ? 1 : int'(need))) begin
            m_fire = 1; m_armed = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (fire !== m_fire) begin
        fails++;
        $display("FAIL %s: fire_o actual %0b expected %0b at %0t", cur_req, fire, m_fire, $time);
      end
      if (fire === 1'b1) fires++;
    end
  end

  task automatic step(input logic a, input logic s, input logic [W-1:0] w);
    @(negedge clk);
    arm = a; smp = s; word = w;
  endtask

  task automatic begin_s(input string r);
    @(negedge clk);
    #1;
    cur_req = r; fires = 0;
    arm = 0; smp = 0; ext_sel = 0; ext_lvl = 0;
  endtask

  task automatic expect_fires(input string r, input int n);
    step(0, 0, '0);
    step(0, 0, '0);
    @(negedge clk);
    #1;
    checks++;
    if (fires != n) begin
      fails++;
      $display("FAIL %s: trigger pulses actual %0d expected %0d", r, fires, n);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    @(negedge clk);
    #1;
    checks++;
    if (fire !== 1'b0) begin
      fails++;
      $display("FAIL R9: fire_o after reset actual %0b expected 0", fire);
    end

    // R1: masked compare, upper byte cared
    begin_s("R1");
    pat = 16'hA5C3; care = 16'hFF00; need = 1;
    step(1, 0, '0);
    step(0, 1, 16'h00C3);
    step(0, 1, 16'h5AC3);
    step(0, 1, 16'hA5FF);
    expect_fires("R1", 1);

    // R2: empty mask fires on first qualified sample
    begin_s("R2");
    pat = 16'h1234; care = '0; need = 1;
    step(1, 0, '0);
    step(0, 1, 16'hFFFF);
    expect_fires("R2", 1);

    // R3: need 0 and need 1 both fire on first match
    begin_s("R3");
    pat = 16'h00F0; care = 16'h00F0; need = 0;
    step(1, 0, '0);
    step(0, 1, 16'h00F7);
    expect_fires("R3", 1);
    begin_s("R3");
    need = 1;
    step(1, 0, '0);
    step(0, 1, 16'hFFF0);
    expect_fires("R3", 1);

    // R4: third match fires, gaps and misses in between
    begin_s("R4");
    pat = 16'hBEEF; care = 16'hFFFF; need = 3;
    step(1, 0, '0);
    step(0, 1, 16'hBEEF);
    step(0, 1, 16'h0000);
    step(0, 0, 16'hBEEF);
    step(0, 1, 16'hBEEF);
    step(0, 1, 16'hBEEE);
    expect_fires("R4", 0);
    step(0, 1, 16'hBEEF);
    expect_fires("R4", 1);

    // R8: no further pulse without re-arm
    begin_s("R8");
    for (int i = 0; i < 5; i++) step(0, 1, 16'hBEEF);
    expect_fires("R8", 0);

    // R5: no strobe, and the arm-cycle sample, are not counted
    begin_s("R5");
    pat = 16'h0F0F; care = 16'hFFFF; need = 2;
    step(1, 1, 16'h0F0F);
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0F0F);
    step(0, 1, 16'h0F0F);
    expect_fires("R5", 0);
    step(0, 1, 16'h0F0F);
    expect_fires("R5", 1);

    // R6: external level overrides pattern
    begin_s("R6");
    pat = 16'h1111; care = 16'hFFFF; need = 1; ext_sel = 1; ext_lvl = 0;
    step(1, 0, '0);
    step(0, 1, 16'h1111);
    step(0, 1, 16'h1111);
    expect_fires("R6", 0);
    ext_lvl = 1;
    step(0, 0, 16'h2222);
    expect_fires("R6", 0);
    step(0, 1, 16'h2222);
    expect_fires("R6", 1);

    // R7: external level ignored when not selected
    begin_s("R7");
    pat = 16'h1111; care = 16'hFFFF; need = 1; ext_sel = 0; ext_lvl = 1;
    step(1, 0, '0);
    for (int i = 0; i < 4; i++) step(0, 1, 16'h2222);
    expect_fires("R7", 0);
    step(0, 1, 16'h1111);
    expect_fires("R7", 1);

    // R9: re-arm clears a partial count
    begin_s("R9");
    pat = 16'h00AA; care = 16'h00FF; need = 3;
    step(1, 0, '0);
    step(0, 1, 16'h12AA);
    step(0, 1, 16'h34AA);
    step(1, 0, '0);
    step(0, 1, 16'h56AA);
    step(0, 1, 16'h78AA);
    expect_fires("R9", 0);
    step(0, 1, 16'h9AAA);
    expect_fires("R9", 1);

    // R10: most significant bit is compared
    begin_s("R10");
    pat = 16'h8000; care = 16'h8000; need = 1;
    step(1, 0, '0);
    step(0, 1, 16'h7FFF);
    expect_fires("R10", 0);
    step(0, 1, 16'h8000);
    expect_fires("R10", 1);

    summary();
  end
endmodule